// File: doc/BRIEF.md
# Discrete-Time PID Duty-Cycle Controller

This block turns one signed error sample per switching period into an unsigned duty-cycle word for a downstream PWM generator. The error is the reference minus the digitized regulated quantity, with every value scaled to the input voltage. The command is built from four terms: the reference word used directly as a feedforward estimate, a proportional term, a derivative term on the change in error since the last sample, and a digital integrator term.

The gains are fixed-point inputs with `FB` fractional bits. The integral gain is capped at one, so the integrator can move the command by a single LSB. That trim is what removes the steady-state limit cycle a pure proportional loop shows around the zero-error bin. The weighted sum is rounded to the duty width and clamped to the command range. While the command is pinned in the direction the error pushes, the integrator stops accumulating.

Top module: `pid_duty_ctrl`

## Requirements
- R1: A synchronous reset drives `duty_o` to 0 and clears the integrator and the stored previous error.
- R2: State and `duty_o` change only on a cycle with `stb_i` high. The new command appears on `duty_o` one clock after the strobe. With `stb_i` low, `duty_o` holds and the integrator does not accumulate.
- R3: The unrounded command in units of 2^-FB LSB is `ref_i*2^FB + kp_i*e + kd_i*(e - e_prev) + ki*I`. Here `kp_i` and `kd_i` are unsigned with FB fractional bits, and `e` is the two's-complement `err_i`.
- R4: The derivative term uses the error held from the previous strobe. That value is 0 after reset.
- R5: Each strobe sets the integrator to `I = I_old + e`, and that updated value is the one used in the same sample's sum. A zero error leaves `I` exactly unchanged.
- R6: The effective integral gain is `min(ki_i, 2^FB)`, so it never exceeds 1.0. With FB=2, a `ki_i` of 7 acts as 4.
- R7: The sum is rounded to the nearest LSB with halves rounded up, computed as `floor((S + 2^(FB-1)) / 2^FB)`.
- R8: A rounded result below 0 gives `duty_o = 0`. A result above `2^DW-1` gives `duty_o = 2^DW-1`.
- R9: The integrator holds its value, and that held value is used in the sum, when the previous `duty_o` is at `2^DW-1` with a positive error, or at 0 with a negative error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| stb_i | input | 1 | Sample strobe, one pulse per switching period |
| err_i | input | EW | Signed error sample |
| ref_i | input | DW | Reference feedforward word |
| kp_i | input | GW | Proportional gain, unsigned, FB fractional bits |
| kd_i | input | GW | Derivative gain, unsigned, FB fractional bits |
| ki_i | input | FB+1 | Integral gain, unsigned, FB fractional bits, capped at 1.0 |
| duty_o | output | DW | Saturated duty-cycle command |

## Verification
Output saturation and the integrator freeze can act in the same sample. The freeze decision depends on the command the previous strobe left at the rail, while the current strobe computes a new command. The bench drives a large error to pin the command high, then applies a further positive error, a negative error against a command pinned at zero, and a negative error right after reset. A later zero-error sample reveals the integrator value through `duty_o`, and that value is compared against both the frozen and the unfrozen arithmetic.

// File: rtl/pid_duty_ctrl.sv
module pid_duty_ctrl #(
  parameter int EW = 8,
  parameter int DW = 10,
  parameter int GW = 8,
  parameter int FB = 2,
  parameter int IW = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_i,
  input  logic                 stb_i,
  input  logic signed [EW-1:0] err_i,
  input  logic        [DW-1:0] ref_i,
  input  logic        [GW-1:0] kp_i,
  input  logic        [GW-1:0] kd_i,
  input  logic        [FB:0]   ki_i,
  output logic        [DW-1:0] duty_o
);
  localparam int SW = GW + IW + DW + 4;
  localparam logic [FB:0] KI_ONE = (FB+1)'(1) << FB;
  localparam logic signed [SW-1:0] IMAX = {{(SW-IW+1){1'b0}}, {(IW-1){1'b1}}};
  localparam logic signed [SW-1:0] IMIN = ~IMAX;
  localparam logic signed [SW-1:0] DMAX = {{(SW-DW){1'b0}}, {DW{1'b1}}};
  localparam logic signed [SW-1:0] HALF = SW'(1) <<< (FB-1);

  logic signed [EW-1:0] e_prev;
  logic signed [IW-1:0] integ;
  logic        [DW-1:0] duty_q;

  logic signed [SW-1:0] e_x, d_x, i_sum, i_nx, ki_x, sum, rnd;
  logic        [DW-1:0] duty_nx;
  logic                 e_pos, e_neg, freeze;

  assign e_neg  = err_i[EW-1];
  assign e_pos  = !err_i[EW-1] && (err_i != '0);
  assign freeze = (duty_q == '1 && e_pos) || (duty_q == '0 && e_neg);

  assign e_x   = SW'(err_i);
  assign d_x   = e_x - SW'(e_prev);
  assign i_sum = SW'(integ) + e_x;
  assign ki_x  = (ki_i > KI_ONE) ? $signed(SW'(KI_ONE)) : $signed(SW'(ki_i));

  always_comb begin
    if (freeze)             i_nx = SW'(integ);
    else if (i_sum > IMAX)  i_nx = IMAX;
    else if (i_sum < IMIN)  i_nx = IMIN;
    else                    i_nx = i_sum;
  end

  assign sum = ($signed(SW'(ref_i)) <<< FB)
             + $signed(SW'(kp_i)) * e_x
             + $signed(SW'(kd_i)) * d_x
             + ki_x * i_nx;
  assign rnd = (sum + HALF) >>> FB;

  always_comb begin
    if (rnd < 0)         duty_nx = '0;
    else if (rnd > DMAX) duty_nx = '1;
    else                 duty_nx = rnd[DW-1:0];
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      e_prev <= '0;
      integ  <= '0;
      duty_q <= '0;
    end else if (stb_i) begin
      e_prev <= err_i;
      integ  <= i_nx[IW-1:0];
      duty_q <= duty_nx;
    end
  end

  assign duty_o = duty_q;
endmodule

// File: rtl/pid_duty_ctrl_chk.sv
module pid_duty_ctrl_chk #(
  parameter int EW = 8,
  parameter int DW = 10,
  parameter int IW = 16
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 stb,
  input logic signed [EW-1:0] err,
  input logic        [DW-1:0] duty,
  input logic signed [IW-1:0] integ
);
  // R1
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (duty == '0 && integ == '0));

  // R2
  a_r2_hold_without_strobe: assert property (@(posedge clk) disable iff (rst)
    !stb |=> ($stable(duty) && $stable(integ)));

  // R5
  a_r5_zero_error_holds: assert property (@(posedge clk) disable iff (rst)
    (stb && err == '0) |=> $stable(integ));

  // R9
  a_r9_freeze_high: assert property (@(posedge clk) disable iff (rst)
    (stb && duty == '1 && !err[EW-1] && err != '0) |=> $stable(integ));

  // R9
  a_r9_freeze_low: assert property (@(posedge clk) disable iff (rst)
    (stb && duty == '0 && err[EW-1]) |=> $stable(integ));
endmodule

bind pid_duty_ctrl pid_duty_ctrl_chk #(.EW(EW), .DW(DW), .IW(IW)) u_chk (
  .clk  (clk_i),
  .rst  (rst_i),
  .stb  (stb_i),
  .err  (err_i),
  .duty (duty_q),
  .integ(integ)
);

// File: tb/tb_pid_duty_ctrl.sv
`timescale 1ns/1ps
module tb_pid_duty_ctrl;
  localparam int EW = 8, DW = 10, GW = 8, FB = 2, IW = 16;
  localparam int NV = 15;
  // defaults: kp 10.0 -> 40, kd 14.0 -> 56, ki 0.25 -> 1, ref 512
  localparam int VEC_E[NV] = '{0, 3, 3, 0, 0, -2, -2, 1, 127, 10, -5, 0, -128, 0, 0};
  localparam int VEC_D[NV] = '{512, 585, 544, 472, 514, 465, 493, 565, 1023, 0, 285, 615, 0, 1023, 513};

  logic                 clk = 0, rst = 1, stb = 0;
  logic signed [EW-1:0] err = '0;
  logic        [DW-1:0] ref_w = 10'd512;
  logic        [GW-1:0] kp = 8'd40, kd = 8'd56;
  logic        [FB:0]   ki = 3'd1;
  logic        [DW-1:0] duty;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  pid_duty_ctrl #(.EW(EW), .DW(DW), .GW(GW), .FB(FB), .IW(IW)) dut (
    .clk_i(clk), .rst_i(rst), .stb_i(stb), .err_i(err), .ref_i(ref_w),
    .kp_i(kp), .kd_i(kd), .ki_i(ki), .duty_o(duty));

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1; stb = 0;
    @(negedge clk); @(negedge clk); rst = 0;
  endtask

  task automatic step(input int e);
    @(negedge clk); err = EW'(e); stb = 1;
    @(negedge clk); stb = 0;
  endtask

  initial begin
    #3_000_000;
    n_chk++; n_fail++;
    $display("FAIL R2 watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    chk("R1 reset duty", int'(duty), 0);

    // R3 R4 R5 R7 R8 R9 table
    for (int i = 0; i < NV; i++) begin
      step(VEC_E[i]);
      chk($sformatf("R3/R5/R7/R8/R9 table step %0d", i), int'(duty), VEC_D[i]);
    end

    // R2: no strobe, error changes, output holds
    @(negedge clk); err = 8'sd50;
    repeat (3) @(negedge clk);
    chk("R2 hold without strobe", int'(duty), 513);
    step(0);
    chk("R2 no accumulation without strobe", int'(duty), 513);

    // R1 R4: reset clears previous error and integrator
    step(4);
    do_reset();
    chk("R1 reset mid-run", int'(duty), 0);
    step(0);
    chk("R4 prev error cleared by reset", int'(duty), 512);

    // R3: feedforward follows ref
    ref_w = 10'd100;
    step(0);
    chk("R3 feedforward", int'(duty), 100);

    // R6: integral gain capped at 1.0
    do_reset();
    ref_w = 10'd512; ki = 3'd7;
    step(5);
    chk("R6 ki clamp", int'(duty), 637);

    // R9: negative error at zero command after reset freezes integrator
    do_reset();
    ref_w = 10'd100; kp = 8'd4; kd = 8'd0; ki = 3'd4;
    step(-3);
    chk("R9 freeze low", int'(duty), 97);
    step(0);
    chk("R9 frozen integrator value", int'(duty), 100);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule